// File: doc/BRIEF.md
# Reset Vector Sequencer

This block brings a 32-bit CPU core out of reset. It filters an active-low external reset pin so that only a low level lasting a minimum number of system clocks counts as a reset. Once a reset is accepted it holds the core in reset. While reset is held it loads the architectural start-up state: stack pointer, interrupt mask level, register bank, clock-gear code and PLL bypass. Shorter dips on the pin are treated as noise and leave the running machine untouched.

When the pin returns high, the core reset is dropped in that same cycle. The sequencer then reads the start address from three consecutive byte locations at a fixed high vector address, over a byte-wide request/valid read port, and builds the 24-bit program counter. A one-cycle run strobe tells the core to begin fetching from that address. If the pin drops again before the vector is complete, the read sequence is abandoned. No run strobe is given until a full-length reset has been seen again.

Top module: `rst_vec_seq`

## Requirements
- R1: A reset is accepted only after `ext_rst_n` has been sampled low on MIN_LOW (default 20) consecutive rising clock edges. `core_rst` is high from the clock after the last of those edges. With 19 low samples or fewer, `core_rst` stays low.
- R2: `core_rst` goes low combinationally in the same cycle that `ext_rst_n` returns high, with no added delay.
- R3: An accepted reset loads `sp` with 0 and `bank` with 0. Both keep those values after release.
- R4: An accepted reset sets the 3-bit `imask` to 3'b111, which masks interrupt levels up to 7.
- R5: An accepted reset sets `pll_bypass` to 1 and `clk_gear` to code 3'd4. The gear code n means divide by 2^n, so code 4 selects divide-by-16.
- R6: After release, exactly three reads are issued in ascending order at addresses 24'hFFFF00, 24'hFFFF01 and 24'hFFFF02. Each read holds `mem_rd_req` and its address until a cycle with `mem_rd_vld` high. The byte read from FFFF00+n is placed in `pc[8n+7:8n]`.
- R7: `run` is high for exactly one clock, in the cycle after the third byte's valid cycle. At that point `pc` is complete, and it holds its value until the next accepted reset.
- R8: If `ext_rst_n` goes low during the vector reads, `mem_rd_req` drops in that same cycle. The sequence is abandoned and no `run` is produced. New reads start only after a fresh full-length reset has been accepted and released.
- R9: A low pulse of fewer than MIN_LOW clocks while the core runs changes none of `pc`, `sp`, `imask`, `bank`, `clk_gear` and `pll_bypass`. It also raises neither `core_rst`, `mem_rd_req` nor `run`.
- R10: Asynchronous `por_n` low clears `pc`, `sp`, `imask`, `bank`, `clk_gear`, `pll_bypass`, `run` and `mem_rd_req` to 0. Afterwards no read is issued until a reset has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| ext_rst_n | input | 1 | External reset pin, active low, filtered by length |
| mem_rd_req | output | 1 | Vector byte read request |
| mem_rd_addr | output | 24 | Address of the byte being read |
| mem_rd_vld | input | 1 | Read data valid |
| mem_rd_data | input | 8 | Read data byte |
| core_rst | output | 1 | Reset held on the CPU core |
| run | output | 1 | One-cycle start strobe to the core |
| pc | output | 24 | Assembled start address |
| sp | output | 32 | Stack pointer start value |
| imask | output | 3 | Interrupt mask level |
| bank | output | 2 | Register bank select |
| clk_gear | output | 3 | Clock divider code, divide by 2^code |
| pll_bypass | output | 1 | PLL bypass flag |

## Verification
The hardest case to reach is a reset that returns in the middle of the vector reads while a request is still open. The stimulus answers the first byte at once. It then holds the second request without a valid response and pulls the pin low on that exact cycle. The test then checks that the request disappears at once, that a following short pulse does not restart the reads, and that only a full-length reset leads to a new vector and a run strobe. The 19-versus-20 cycle boundary is tested both before the first reset and while the core is running.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_HOLD  = 2'd1,
      FS_FETCH = 2'd2,
      FS_RUN   = 2'd3
   } fetch_state_e;

endpackage

// File: rtl/rsv_lowfilter.sv
module rsv_lowfilter #(
   parameter int MIN_LOW = 20
) (
   input  logic clk,
   input  logic por_n,
   input  logic ext_rst_n,
   output logic accept_now,
   output logic accepted_q
);
   localparam int CNT_W = $clog2(MIN_LOW + 1);

   logic [CNT_W-1:0] low_cnt;

   generate
      if (MIN_LOW < 1) begin : g_bad_min
         $error("rsv_lowfilter: MIN_LOW must be at least 1");
      end
   endgenerate

   // Consecutive low samples, saturating at MIN_LOW, cleared by any high sample.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         low_cnt <= '0;
      end else if (ext_rst_n) begin
         low_cnt <= '0;
      end else if (low_cnt != CNT_W'(MIN_LOW)) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   // True on the edge that records the MIN_LOW-th low sample and later ones.
   assign accept_now = !ext_rst_n && (low_cnt >= CNT_W'(MIN_LOW - 1));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) accepted_q <= 1'b0;
      else        accepted_q <= accept_now;
   end

   AST_LOW_BEFORE_ACCEPT: assert property (@(posedge clk) disable iff (!por_n)
      $rose(accepted_q) |-> $past(!ext_rst_n));   // R1

endmodule

// File: rtl/rsv_archregs.sv
module rsv_archregs #(
   parameter int               SP_W     = 32,
   parameter int               IMASK_W  = 3,
   parameter int               BANK_W   = 2,
   parameter int               GEAR_W   = 3,
   parameter logic [GEAR_W-1:0] GEAR_RST = 3'd4
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               load,
   input  logic               accepted_q,
   output logic [SP_W-1:0]    sp,
   output logic [IMASK_W-1:0] imask,
   output logic [BANK_W-1:0]  bank,
   output logic [GEAR_W-1:0]  clk_gear,
   output logic               pll_bypass
);
   generate
      if (SP_W < 1 || IMASK_W < 1 || BANK_W < 1 || GEAR_W < 1) begin : g_bad_w
         $error("rsv_archregs: every field width must be at least 1");
      end
   endgenerate

   // Forced while a reset is accepted; untouched otherwise.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sp         <= '0;
         imask      <= '0;
         bank       <= '0;
         clk_gear   <= '0;
         pll_bypass <= 1'b0;
      end else if (load) begin
         sp         <= '0;
         imask      <= '1;
         bank       <= '0;
         clk_gear   <= GEAR_RST;
         pll_bypass <= 1'b1;
      end
   end

   AST_STACK_BANK_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
      accepted_q |-> (sp == '0 && bank == '0));   // R3
   AST_MASK_FULL: assert property (@(posedge clk) disable iff (!por_n)
      accepted_q |-> (&imask));   // R4
   AST_CLOCK_SLOW: assert property (@(posedge clk) disable iff (!por_n)
      accepted_q |-> (pll_bypass && clk_gear == GEAR_RST));   // R5

endmodule

// File: rtl/rsv_vecfetch.sv
module rsv_vecfetch
   import rsv_pkg::*;
#(
   parameter int                PC_W     = 24,
   parameter int                ADDR_W   = 24,
   parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFF00
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              accept_now,
   input  logic              ext_rst_n,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_vld,
   input  logic [7:0]        mem_rd_data,
   output logic [PC_W-1:0]   pc,
   output logic              run
);
   localparam int NB    = PC_W / 8;
   localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

   fetch_state_e     st;
   logic [IDX_W-1:0] idx;
   logic             take;
   logic             last;

   generate
      if (PC_W % 8 != 0 || PC_W < 8) begin : g_bad_pc
         $error("rsv_vecfetch: PC_W must be a positive multiple of 8");
      end
   endgenerate

   assign mem_rd_req  = (st == FS_FETCH) && ext_rst_n;
   assign mem_rd_addr = VEC_BASE + ADDR_W'(idx);
   assign take        = mem_rd_req && mem_rd_vld;
   assign last        = (idx == IDX_W'(NB - 1));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st  <= FS_IDLE;
         idx <= '0;
         run <= 1'b0;
      end else begin
         run <= 1'b0;
         if (accept_now) begin
            st  <= FS_HOLD;
            idx <= '0;
         end else begin
            case (st)
               FS_HOLD: begin
                  if (ext_rst_n) begin
                     st  <= FS_FETCH;
                     idx <= '0;
                  end
               end
               FS_FETCH: begin
                  if (!ext_rst_n) begin
                     st <= FS_IDLE;
                  end else if (take) begin
                     if (last) begin
                        st  <= FS_RUN;
                        run <= 1'b1;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // One byte lane per vector byte, ascending address order.
   for (genvar g = 0; g < NB; g++) begin : g_lane
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            pc[g*8 +: 8] <= '0;
         end else if (take && idx == IDX_W'(g)) begin
            pc[g*8 +: 8] <= mem_rd_data;
         end
      end
   end

   AST_RUN_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
      run |=> !run);   // R7
   AST_PC_HELD: assert property (@(posedge clk) disable iff (!por_n)
      (st == FS_RUN && $past(st == FS_RUN)) |-> $stable(pc));   // R7
   AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!por_n)
      mem_rd_req |-> ((mem_rd_addr - VEC_BASE) < ADDR_W'(NB)));   // R6
   AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!por_n)
      (st == FS_FETCH && !ext_rst_n) |=> (!mem_rd_req && !run));   // R8

endmodule

// File: rtl/rst_vec_seq.sv
module rst_vec_seq #(
   parameter int                MIN_LOW  = 20,
   parameter int                PC_W     = 24,
   parameter int                ADDR_W   = 24,
   parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFF00,
   parameter int                SP_W     = 32,
   parameter int                IMASK_W  = 3,
   parameter int                BANK_W   = 2,
   parameter int                GEAR_W   = 3,
   parameter logic [GEAR_W-1:0] GEAR_RST = 3'd4
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               ext_rst_n,
   output logic               mem_rd_req,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic               mem_rd_vld,
   input  logic [7:0]         mem_rd_data,
   output logic               core_rst,
   output logic               run,
   output logic [PC_W-1:0]    pc,
   output logic [SP_W-1:0]    sp,
   output logic [IMASK_W-1:0] imask,
   output logic [BANK_W-1:0]  bank,
   output logic [GEAR_W-1:0]  clk_gear,
   output logic               pll_bypass
);
   logic accept_now;
   logic accepted_q;

   rsv_lowfilter #(.MIN_LOW(MIN_LOW)) u_filt (
      .clk        (clk),
      .por_n      (por_n),
      .ext_rst_n  (ext_rst_n),
      .accept_now (accept_now),
      .accepted_q (accepted_q)
   );

   rsv_archregs #(
      .SP_W(SP_W), .IMASK_W(IMASK_W), .BANK_W(BANK_W),
      .GEAR_W(GEAR_W), .GEAR_RST(GEAR_RST)
   ) u_arch (
      .clk        (clk),
      .por_n      (por_n),
      .load       (accept_now),
      .accepted_q (accepted_q),
      .sp         (sp),
      .imask      (imask),
      .bank       (bank),
      .clk_gear   (clk_gear),
      .pll_bypass (pll_bypass)
   );

   rsv_vecfetch #(
      .PC_W(PC_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)
   ) u_fetch (
      .clk         (clk),
      .por_n       (por_n),
      .accept_now  (accept_now),
      .ext_rst_n   (ext_rst_n),
      .mem_rd_req  (mem_rd_req),
      .mem_rd_addr (mem_rd_addr),
      .mem_rd_vld  (mem_rd_vld),
      .mem_rd_data (mem_rd_data),
      .pc          (pc),
      .run         (run)
   );

   // Released the moment the pin goes high.
   assign core_rst = accepted_q && !ext_rst_n;

   AST_NO_READ_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
      core_rst |-> !mem_rd_req);   // R8
   AST_RUN_AFTER_DATA: assert property (@(posedge clk) disable iff (!por_n)
      run |-> $past(mem_rd_vld && mem_rd_req));   // R7

endmodule

// File: tb/rst_vec_seq_tb.sv
module rst_vec_seq_tb;
   logic        clk = 1'b0;
   logic        por_n;
   logic        ext_rst_n;
   logic        mem_rd_req;
   logic [23:0] mem_rd_addr;
   logic        mem_rd_vld;
   logic [7:0]  mem_rd_data;
   logic        core_rst;
   logic        run;
   logic [23:0] pc;
   logic [31:0] sp;
   logic [2:0]  imask;
   logic [1:0]  bank;
   logic [2:0]  clk_gear;
   logic        pll_bypass;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rst_vec_seq u_dut (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_vld(mem_rd_vld), .mem_rd_data(mem_rd_data),
      .core_rst(core_rst), .run(run), .pc(pc), .sp(sp), .imask(imask),
      .bank(bank), .clk_gear(clk_gear), .pll_bypass(pll_bypass)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic hold_low(input int n);
      ext_rst_n = 1'b0;
      repeat (n) tick();
   endtask

   task automatic check_reset_state();
      chk("R1", "core_rst held", 32'(core_rst), 32'd1);
      chk("R3", "sp", sp, 32'd0);
      chk("R3", "bank", 32'(bank), 32'd0);
      chk("R4", "imask", 32'(imask), 32'd7);
      chk("R5", "pll_bypass", 32'(pll_bypass), 32'd1);
      chk("R5", "clk_gear", 32'(clk_gear), 32'd4);
      chk("R8", "no read in reset", 32'(mem_rd_req), 32'd0);
   endtask

   task automatic release_pin();
      ext_rst_n = 1'b1;
      #1;
      chk("R2", "core_rst drops same cycle", 32'(core_rst), 32'd0);
   endtask

   // Serve three vector reads with the given latencies, then check run and pc.
   task automatic serve_vector(input logic [23:0] vec, input int l0,
                               input int l1, input int l2);
      int lat;
      tick();
      for (int b = 0; b < 3; b++) begin
         lat = (b == 0) ? l0 : (b == 1) ? l1 : l2;
         chk("R6", "read request", 32'(mem_rd_req), 32'd1);
         chk("R6", "read address", 32'(mem_rd_addr), 32'(24'hFFFF00 + b));
         chk("R7", "no early run", 32'(run), 32'd0);
         repeat (lat) begin
            tick();
            chk("R6", "request held", 32'(mem_rd_req), 32'd1);
            chk("R6", "address held", 32'(mem_rd_addr), 32'(24'hFFFF00 + b));
         end
         mem_rd_vld  = 1'b1;
         mem_rd_data = vec[b*8 +: 8];
         tick();
         mem_rd_vld  = 1'b0;
         mem_rd_data = 8'h00;
      end
      chk("R7", "run strobe", 32'(run), 32'd1);
      chk("R6", "assembled pc", 32'(pc), 32'(vec));
      chk("R6", "no fourth read", 32'(mem_rd_req), 32'd0);
      tick();
      chk("R7", "run one cycle", 32'(run), 32'd0);
      repeat (4) tick();
      chk("R7", "pc stable", 32'(pc), 32'(vec));
      chk("R6", "reads finished", 32'(mem_rd_req), 32'd0);
      chk("R3", "sp kept after release", sp, 32'd0);
   endtask

   task automatic t_por();
      chk("R10", "pc", 32'(pc), 32'd0);
      chk("R10", "imask", 32'(imask), 32'd0);
      chk("R10", "gear and bypass", 32'({clk_gear, pll_bypass}), 32'd0);
      chk("R10", "run", 32'(run), 32'd0);
      chk("R10", "core_rst", 32'(core_rst), 32'd0);
      repeat (5) tick();
      chk("R10", "no read before reset", 32'(mem_rd_req), 32'd0);
   endtask

   task automatic t_short_first();
      hold_low(19);
      chk("R1", "19 lows not accepted", 32'(core_rst), 32'd0);
      chk("R1", "imask untouched", 32'(imask), 32'd0);
      ext_rst_n = 1'b1;
      repeat (4) begin
         tick();
         chk("R1", "no read after short pulse", 32'(mem_rd_req), 32'd0);
      end
   endtask

   task automatic t_full(input int lows, input logic [23:0] vec,
                         input int l0, input int l1, input int l2);
      hold_low(lows);
      check_reset_state();
      release_pin();
      serve_vector(vec, l0, l1, l2);
   endtask

   task automatic t_glitch_running(input int lows);
      logic [23:0] pc_before;
      pc_before = pc;
      hold_low(lows);
      chk("R9", "core_rst stays low", 32'(core_rst), 32'd0);
      ext_rst_n = 1'b1;
      repeat (6) begin
         tick();
         chk("R9", "no read", 32'(mem_rd_req), 32'd0);
         chk("R9", "no run", 32'(run), 32'd0);
      end
      chk("R9", "pc kept", 32'(pc), 32'(pc_before));
      chk("R9", "imask kept", 32'(imask), 32'd7);
      chk("R9", "gear kept", 32'({clk_gear, pll_bypass}), 32'({3'd4, 1'b1}));
   endtask

   task automatic t_abort();
      hold_low(20);
      check_reset_state();
      release_pin();
      tick();
      chk("R6", "first read", 32'(mem_rd_req), 32'd1);
      mem_rd_vld  = 1'b1;
      mem_rd_data = 8'h99;
      tick();
      mem_rd_vld  = 1'b0;
      chk("R6", "second read", 32'(mem_rd_addr), 32'(24'hFFFF01));
      ext_rst_n = 1'b0;
      #1;
      chk("R8", "request drops at once", 32'(mem_rd_req), 32'd0);
      repeat (5) tick();
      ext_rst_n = 1'b1;
      repeat (8) begin
         tick();
         chk("R8", "no read after abort", 32'(mem_rd_req), 32'd0);
         chk("R8", "no run after abort", 32'(run), 32'd0);
      end
      t_full(22, 24'hC0FFEE, 1, 0, 2);
   endtask

   initial begin
      por_n       = 1'b0;
      ext_rst_n   = 1'b1;
      mem_rd_vld  = 1'b0;
      mem_rd_data = 8'h00;
      repeat (3) tick();
      por_n = 1'b1;
      tick();
      t_por();
      t_short_first();
      t_full(25, 24'h7E3CA5, 0, 2, 1);
      t_glitch_running(19);
      t_full(20, 24'h563412, 1, 1, 1);
      t_glitch_running(3);
      t_abort();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule